// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block measures an external pulse-width-modulated signal. It returns the length of each full cycle and the length of each high phase, both as counts of prescaled clock ticks. One input pin feeds two capture paths. The rising-edge path stores the period and then clears the counter. The falling-edge path stores the high time. Because the counter restarts on every rising edge, software or downstream logic can read both values directly, with no subtraction.

The input is synchronised before any edge is detected. An internal prescaler divides the clock by `psc + 1` to set the counter's rate. Each capture is announced by a one-cycle pulse that can serve as an interrupt request. If no rising edge arrives before the counter reaches its top value, the counter holds there and an overflow flag is raised.

Top module: `pwm_meter`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first capture, `period_o`, `duty_o`, `period_vld`, `duty_vld` and `overflow_o` are all zero.
- R2: An input level change set up before clock edge k is acted on at edge k+2. The matching capture pulse is high between edges k+2 and k+3, and not before.
- R3: The counter advances once every `psc + 1` clock cycles. A detected rising edge clears both the counter and the prescaler phase.
- R4: On each detected rising edge after the first, `period_o` takes the value `floor(T / (psc+1))`, where T is the clock count between the two rising edges, and `period_vld` pulses.
- R5: On each detected falling edge after the first rising edge, `duty_o` takes the value `floor(H / (psc+1))`, where H is the clock count of the high phase, and `duty_vld` pulses.
- R6: The first rising edge after reset only starts a measurement. It raises no `period_vld` and leaves `period_o` unchanged.
- R7: Before the first rising edge, the counter does not run and `overflow_o` stays low.
- R8: If the counter reaches its top value 2^CNT_W−1, it holds there and `overflow_o` goes high. A capture taken in that state returns the top value. The next detected rising edge clears `overflow_o`.
- R9: `period_vld` and `duty_vld` are each exactly one cycle wide and are never high together. `period_o` and `duty_o` change only in the cycle their pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Asynchronous PWM signal to be measured |
| psc | input | PSC_W (16) | Prescaler; the counter ticks every psc+1 clocks |
| period_o | output | CNT_W (16) | Last captured period |
| duty_o | output | CNT_W (16) | Last captured high time |
| period_vld | output | 1 | One-cycle pulse when period_o is updated |
| duty_vld | output | 1 | One-cycle pulse when duty_o is updated |
| overflow_o | output | 1 | Counter saturated during the current measurement |

## Verification
The bench checks the exact cycle of each capture pulse. A design with one synchroniser stage too many or too few would pulse a cycle early or late. It checks that the arming rising edge reports nothing, so a design that treats the first edge as a period end would emit a spurious capture. It measures with several prescaler values and with high times that are not multiples of the divide ratio. A design that forgets to clear the prescaler phase on a rising edge, or that captures the count from before the increment, would be off by one. It holds the input high past the counter's range, so a counter that wraps instead of saturating, or an overflow flag that never clears, would be caught.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;

    // Edge events seen on the synchronised input
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/pwm_meter_sync.sv
module pwm_meter_sync #(
    parameter int STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      din,
    output pwm_meter_pkg::edge_ev_t   ev
);
    localparam int CHAIN_W = STAGES + 1;   // sync stages plus one history bit

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], din};
        ev.rise    =  st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
        ev.fall    = ~st_q.chain[STAGES-1] &  st_q.chain[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_meter_tick.sv
module pwm_meter_tick #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // >= covers a prescaler lowered while the phase is already past it
        tick = en && (st_q.phase >= psc);
        if (clr || !en || tick) st_d.phase = '0;
        else                    st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_meter_core.sv
module pwm_meter_core #(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pwm_meter_pkg::edge_ev_t  ev,
    input  logic                     tick,
    output logic [CNT_W-1:0]         cnt,
    output logic [CNT_W-1:0]         period,
    output logic [CNT_W-1:0]         duty,
    output logic                     period_pls,
    output logic                     duty_pls,
    output logic                     ovf,
    output logic                     armed
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             period_pls;
        logic             duty_pls;
        logic             ovf;
        logic             armed;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] adv;

    always_comb begin
        st_d            = st_q;
        st_d.period_pls = 1'b0;
        st_d.duty_pls   = 1'b0;

        // value the counter holds after this edge, saturating at TOP
        if (st_q.armed && tick && (st_q.cnt != TOP)) adv = st_q.cnt + 1'b1;
        else                                         adv = st_q.cnt;

        st_d.cnt = adv;
        if (st_q.armed && (adv == TOP)) st_d.ovf = 1'b1;

        if (ev.rise) begin
            if (st_q.armed) begin
                st_d.period     = adv;
                st_d.period_pls = 1'b1;
            end
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            st_d.ovf   = 1'b0;
        end else if (ev.fall && st_q.armed) begin
            st_d.duty     = adv;
            st_d.duty_pls = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt        = st_q.cnt;
    assign period     = st_q.period;
    assign duty       = st_q.duty;
    assign period_pls = st_q.period_pls;
    assign duty_pls   = st_q.duty_pls;
    assign ovf        = st_q.ovf;
    assign armed      = st_q.armed;
endmodule

// File: rtl/pwm_meter.sv
module pwm_meter #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             period_vld,
    output logic             duty_vld,
    output logic             overflow_o
);
    pwm_meter_pkg::edge_ev_t ev;
    logic                    tick;
    logic                    armed;
    logic [CNT_W-1:0]        cnt_w;

    pwm_meter_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwm_in),
        .ev    (ev)
    );

    pwm_meter_tick #(.PSC_W(PSC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (armed),
        .clr   (ev.rise),
        .psc   (psc),
        .tick  (tick)
    );

    pwm_meter_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .tick       (tick),
        .cnt        (cnt_w),
        .period     (period_o),
        .duty       (duty_o),
        .period_pls (period_vld),
        .duty_pls   (duty_vld),
        .ovf        (overflow_o),
        .armed      (armed)
    );
endmodule

// File: rtl/pwm_meter_chk.sv
module pwm_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] duty_o,
    input logic             period_vld,
    input logic             duty_vld,
    input logic             overflow_o,
    input logic             armed,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({period_vld, duty_vld}));

    assert_period_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !period_vld |-> $stable(period_o));

    assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_vld |-> $stable(duty_o));

    assert_ovf_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (cnt == TOP));

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overflow_o) |-> period_vld);

    assert_idle_before_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (cnt == '0 && !overflow_o && !period_vld && !duty_vld));
endmodule

bind pwm_meter pwm_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_o   (period_o),
    .duty_o     (duty_o),
    .period_vld (period_vld),
    .duty_vld   (duty_vld),
    .overflow_o (overflow_o),
    .armed      (armed),
    .cnt        (cnt_w)
);

// File: tb/sim_pwm_meter.sv
`timescale 1ns/1ps
module sim_pwm_meter;
    localparam int CW  = 8;
    localparam int PW  = 16;
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic [PW-1:0] psc = '0;
    logic [CW-1:0] period_o, duty_o;
    logic          period_vld, duty_vld, overflow_o;

    int checks = 0;
    int errors = 0;
    int pv_cnt = 0;
    int dv_cnt = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_meter #(.CNT_W(CW), .PSC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .psc(psc),
        .period_o(period_o), .duty_o(duty_o),
        .period_vld(period_vld), .duty_vld(duty_vld), .overflow_o(overflow_o)
    );

    always @(posedge clk) begin
        if (period_vld) pv_cnt <= pv_cnt + 1;
        if (duty_vld)   dv_cnt <= dv_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        wait_n(3);
        chk("R1 period_o in reset", period_o, 0);
        chk("R1 duty_o in reset", duty_o, 0);
        chk("R1 vld in reset", {period_vld, duty_vld}, 0);
        chk("R1 overflow in reset", overflow_o, 0);
        rst_n = 1'b1;
        wait_n(20);
        chk("R7 no overflow while idle", overflow_o, 0);
        chk("R1 outputs idle after reset", {period_o, duty_o}, 0);
    endtask

    // first rise arms only; its falling edge yields a duty capture
    task automatic t_arm;
        psc = 0;
        pwm_in = 1'b1;
        wait_n(5);
        chk("R6 no period pulse on arming edge", pv_cnt, 0);
        chk("R6 period_o unchanged", period_o, 0);
        pwm_in = 1'b0;
        wait_n(4);
        chk("R5 duty after arm, psc=0 H=5", duty_o, 5);
        chk("R5 duty pulse count", dv_cnt, 1);
        wait_n(10);
    endtask

    // high H, low L, then rise; checks pulse timing and both captures
    task automatic t_measure(input int p, input int h, input int l);
        int pv0;
        psc = p[PW-1:0];
        pwm_in = 1'b1;
        wait_n(h);
        pwm_in = 1'b0;
        wait_n(l);
        pv0 = pv_cnt;
        pwm_in = 1'b1;
        wait_n(2);
        chk("R2 no period pulse before edge k+2", period_vld, 0);
        wait_n(1);
        chk("R2 period pulse after edge k+2", period_vld, 1);
        wait_n(1);
        chk("R9 period pulse one cycle wide", period_vld, 0);
        chk("R9 one period pulse per cycle", pv_cnt - pv0, 1);
        chk($sformatf("R4 period psc=%0d T=%0d", p, h + l), period_o, (h + l) / (p + 1));
        chk($sformatf("R5 duty psc=%0d H=%0d", p, h), duty_o, h / (p + 1));
        pwm_in = 1'b0;
        wait_n(8);
    endtask

    task automatic t_overflow;
        psc = 0;
        pwm_in = 1'b1;
        wait_n(TOP + 40);
        chk("R8 overflow set at saturation", overflow_o, 1);
        pwm_in = 1'b0;
        wait_n(4);
        chk("R8 duty holds top value", duty_o, TOP);
        chk("R8 overflow stays until rise", overflow_o, 1);
        pwm_in = 1'b1;
        wait_n(4);
        chk("R8 period holds top value", period_o, TOP);
        chk("R8 overflow cleared by rise", overflow_o, 0);
        pwm_in = 1'b0;
        wait_n(8);
    endtask

    initial begin
        t_reset();
        t_arm();
        t_measure(0, 10, 20);   // R4 R5
        t_measure(3, 13, 30);   // R3: 3 and 10 with remainders
        t_measure(1, 7, 8);     // R3: 3 and 7
        t_measure(4, 4, 9);     // R3: high shorter than one tick -> 0
        t_overflow();
        t_measure(0, 6, 6);     // recovery after overflow
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule